// File: doc/BRIEF.md
# Serial Receiver Wakeup Controller

This block decides when a sleeping serial receiver on a shared multi-drop line starts paying attention again. A receiver core feeds it per-bit events: a pulse when a start bit is found, a strobe for each sampled data bit, a strobe when the stop bit is sampled, a tick once per bit time, and the sampled line level. Four configuration inputs select the wakeup method (idle line or address mark), the character length (8 or 9 data bits), where the idle count begins (right after the start bit, or only after the stop bit), and whether an idle line raises the idle flag while the receiver sleeps.

Software puts the receiver to sleep with a one-cycle request. While it sleeps, characters on the line raise no flags. In idle-line wakeup, a full character time of idle level wakes the receiver. In address-mark wakeup, a character whose last data bit is 1 wakes it as soon as that bit is sampled, and that character is then delivered. The outputs are the sleep state, a receive-data-full flag, an idle flag and a combined interrupt request.

Top module: `rxw_wake_ctl`

## Requirements
- R1: After reset, sleep_o, rdf_o, idle_o and irq_o are all 0.
- R2: A one-cycle pulse on sleep_req makes sleep_o 1 from the next cycle. If a wakeup happens in the same cycle, the request wins.
- R3: With cfg_addr_wake=0, a sleeping receiver clears sleep_o once the idle count reaches a full character time: 10 line-high bit ticks when cfg_nine_bit=0, and 11 when cfg_nine_bit=1.
- R4: With cfg_idle_post_stop=0, the idle count starts after the start-bit pulse. Trailing 1 data bits and the stop bit count toward it. A data bit of 0 restarts the count from 0.
- R5: With cfg_idle_post_stop=1, the idle count starts only after the stop-bit strobe. Neither the stop bit nor any data bit counts.
- R6: With cfg_idle_flag_asleep=0, an idle detection while sleep_o=1 does not set idle_o. This holds both when the detection wakes the receiver and when it does not (address-mark mode).
- R7: An idle detection while awake sets idle_o. With cfg_idle_flag_asleep=1, it also sets idle_o while asleep.
- R8: With cfg_addr_wake=1, a data strobe for the last data bit (bit 8 of 8, or bit 9 of 9, sent LSB first) with line_lvl=1 clears sleep_o on the next cycle, before the stop bit. That character then sets rdf_o at its stop strobe. Idle detections do not wake the receiver in this mode.
- R9: A stop strobe sets rdf_o only if sleep_o was 0 in that cycle. Characters received while asleep, including address-mark characters whose last bit is 0, leave rdf_o unchanged.
- R10: After an idle detection, no further idle detection occurs until a new start bit. Bit ticks with line_lvl=0 never count as idle.
- R11: rdf_clr and idle_clr clear their flags on the next cycle. A set event in the same cycle wins over the clear.
- R12: irq_o is (rdf_o AND ie_rx) OR (idle_o AND ie_idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_wake | input | 1 | 1: address-mark wakeup, 0: idle-line wakeup |
| cfg_nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_idle_post_stop | input | 1 | 1: idle count starts after the stop bit, 0: after the start bit |
| cfg_idle_flag_asleep | input | 1 | 1: idle detection sets idle_o even while asleep |
| sleep_req | input | 1 | Pulse: enter sleep |
| rdf_clr | input | 1 | Pulse: clear rdf_o |
| idle_clr | input | 1 | Pulse: clear idle_o |
| ie_rx | input | 1 | Interrupt enable for rdf_o |
| ie_idle | input | 1 | Interrupt enable for idle_o |
| rx_start | input | 1 | Start bit detected |
| rx_data_stb | input | 1 | A data bit was sampled; its value is line_lvl |
| rx_stop_stb | input | 1 | The stop bit was sampled |
| bit_tick | input | 1 | One pulse per bit time |
| line_lvl | input | 1 | Sampled line level |
| sleep_o | output | 1 | Receiver asleep |
| rdf_o | output | 1 | Receive data full flag |
| idle_o | output | 1 | Idle line flag |
| irq_o | output | 1 | Interrupt request |

## Verification
If the idle counter starts at the wrong point, or counts one tick too many or too few, sleep_o or idle_o changes one bit time early or late. That shows up at the port one cycle after the deciding tick. A wrong data-bit index in address-mark mode shows as sleep_o falling on the wrong strobe, or never falling. A wrong sleep qualification shows as rdf_o rising for a character that arrived while asleep, one cycle after its stop strobe. Because the bench compares every output on every cycle, any such error is reported within one clock of the event that exposes it.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    // data bits in the short character mode; the long mode adds one
    localparam int BASE_BITS = 8;

    typedef struct packed {
        logic addr_wake;
        logic nine_bit;
        logic idle_post_stop;
        logic idle_flag_asleep;
    } rxw_cfg_t;
endpackage

// File: rtl/rxw_idle_cnt.sv
module rxw_idle_cnt #(
    parameter int BASE = rxw_pkg::BASE_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nine_bit,
    input  logic post_stop,
    input  logic rx_start,
    input  logic rx_stop_stb,
    input  logic bit_tick,
    input  logic line_lvl,
    output logic idle_hit
);
    localparam int CW = $clog2(BASE + 4);
    localparam logic [CW-1:0] LAST_SHORT = CW'(BASE + 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(BASE + 2);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CW-1:0] last_w;

    always_comb begin
        st_d     = st_q;
        idle_hit = 1'b0;
        last_w   = nine_bit ? LAST_LONG : LAST_SHORT;
        if (rx_start) begin
            st_d.cnt   = '0;
            st_d.armed = !post_stop;
        end else begin
            if (bit_tick) begin
                if (!line_lvl) begin
                    st_d.cnt = '0;
                end else if (st_q.armed) begin
                    if (st_q.cnt == last_w) begin
                        idle_hit   = 1'b1;
                        st_d.cnt   = '0;
                        st_d.armed = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            if (rx_stop_stb && post_stop) begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // count never passes the longest character time (R3)
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_LONG);
    // a disarmed counter holds at zero until re-armed (R10)
    assert_disarm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !rx_start && !(rx_stop_stb && post_stop)) |=> (st_q.cnt == $past(st_q.cnt) || st_q.cnt == '0));
endmodule

// File: rtl/rxw_msb_track.sv
module rxw_msb_track #(
    parameter int BASE = rxw_pkg::BASE_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nine_bit,
    input  logic rx_start,
    input  logic rx_data_stb,
    input  logic line_lvl,
    output logic msb_one
);
    localparam int IW = $clog2(BASE + 2);
    localparam logic [IW-1:0] IDX_SAT = IW'(BASE + 1);

    typedef struct packed {
        logic [IW-1:0] idx;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic [IW-1:0] msb_idx;

    always_comb begin
        st_d    = st_q;
        msb_idx = nine_bit ? IW'(BASE) : IW'(BASE - 1);
        msb_one = 1'b0;
        if (rx_start) begin
            st_d.idx = '0;
        end else if (rx_data_stb) begin
            msb_one = (st_q.idx == msb_idx) && line_lvl;
            if (st_q.idx != IDX_SAT) st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // index saturates at one past the longest character (R8)
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_SAT);
endmodule

// File: rtl/rxw_wake_ctl.sv
module rxw_wake_ctl #(
    parameter int BASE = rxw_pkg::BASE_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_addr_wake,
    input  logic cfg_nine_bit,
    input  logic cfg_idle_post_stop,
    input  logic cfg_idle_flag_asleep,
    input  logic sleep_req,
    input  logic rdf_clr,
    input  logic idle_clr,
    input  logic ie_rx,
    input  logic ie_idle,
    input  logic rx_start,
    input  logic rx_data_stb,
    input  logic rx_stop_stb,
    input  logic bit_tick,
    input  logic line_lvl,
    output logic sleep_o,
    output logic rdf_o,
    output logic idle_o,
    output logic irq_o
);
    import rxw_pkg::*;

    typedef struct packed {
        logic sleep;
        logic rdf;
        logic idle;
    } flag_st_t;

    rxw_cfg_t cfg;
    flag_st_t st_d, st_q;
    logic idle_hit, msb_one, wake;

    assign cfg = '{addr_wake: cfg_addr_wake, nine_bit: cfg_nine_bit,
                   idle_post_stop: cfg_idle_post_stop,
                   idle_flag_asleep: cfg_idle_flag_asleep};

    rxw_idle_cnt #(.BASE(BASE)) u_idle (
        .clk(clk), .rst_n(rst_n), .nine_bit(cfg.nine_bit),
        .post_stop(cfg.idle_post_stop), .rx_start(rx_start),
        .rx_stop_stb(rx_stop_stb), .bit_tick(bit_tick),
        .line_lvl(line_lvl), .idle_hit(idle_hit));

    rxw_msb_track #(.BASE(BASE)) u_msb (
        .clk(clk), .rst_n(rst_n), .nine_bit(cfg.nine_bit),
        .rx_start(rx_start), .rx_data_stb(rx_data_stb),
        .line_lvl(line_lvl), .msb_one(msb_one));

    always_comb begin
        st_d = st_q;
        wake = st_q.sleep && (cfg.addr_wake ? msb_one : idle_hit);
        if (sleep_req)  st_d.sleep = 1'b1;
        else if (wake)  st_d.sleep = 1'b0;
        if (rx_stop_stb && !st_q.sleep) st_d.rdf = 1'b1;
        else if (rdf_clr)               st_d.rdf = 1'b0;
        if (idle_hit && (!st_q.sleep || cfg.idle_flag_asleep)) st_d.idle = 1'b1;
        else if (idle_clr)                                       st_d.idle = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sleep_o = st_q.sleep;
    assign rdf_o   = st_q.rdf;
    assign idle_o  = st_q.idle;
    assign irq_o   = (st_q.rdf & ie_rx) | (st_q.idle & ie_idle);

    assert_sleep_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> sleep_o);
    assert_wake_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> $past(idle_hit || msb_one));
    assert_rdf_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdf_o) |-> ($past(rx_stop_stb) && !$past(sleep_o)));
    assert_idle_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(idle_hit));
endmodule

// File: tb/rxw_wake_ctl_tb.sv
`timescale 1ns/1ps
module rxw_wake_ctl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_addr = 0, cfg_nine = 0, cfg_ilt = 0, cfg_rwid = 0;
    logic sleep_req = 0, rdf_clr = 0, idle_clr = 0, ie_rx = 0, ie_idle = 0;
    logic rx_start = 0, rx_data_stb = 0, rx_stop_stb = 0, bit_tick = 0, line_lvl = 1;
    logic sleep_o, rdf_o, idle_o, irq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int sleep_after_msb = -1;

    // reference model state
    int m_sleep = 0, m_rdf = 0, m_idle = 0, m_cnt = 0, m_arm = 0, m_idx = 0;

    always #4 clk = ~clk;

    rxw_wake_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr_wake(cfg_addr), .cfg_nine_bit(cfg_nine),
        .cfg_idle_post_stop(cfg_ilt), .cfg_idle_flag_asleep(cfg_rwid),
        .sleep_req(sleep_req), .rdf_clr(rdf_clr), .idle_clr(idle_clr),
        .ie_rx(ie_rx), .ie_idle(ie_idle), .rx_start(rx_start),
        .rx_data_stb(rx_data_stb), .rx_stop_stb(rx_stop_stb),
        .bit_tick(bit_tick), .line_lvl(line_lvl),
        .sleep_o(sleep_o), .rdf_o(rdf_o), .idle_o(idle_o), .irq_o(irq_o));

    always @(posedge clk) begin
        int frame, nb, hit, wk, old_sleep;
        if (!rst_n) begin
            m_sleep = 0; m_rdf = 0; m_idle = 0; m_cnt = 0; m_arm = 0; m_idx = 0;
        end else begin
            frame = cfg_nine ? 11 : 10;
            nb = cfg_nine ? 9 : 8;
            hit = 0; wk = 0; old_sleep = m_sleep;
            if (rx_start) begin
                m_cnt = 0; m_arm = cfg_ilt ? 0 : 1; m_idx = 0;
            end else begin
                if (rx_data_stb) begin
                    if (m_idx == nb - 1 && line_lvl && cfg_addr && old_sleep) wk = 1;
                    if (m_idx < 9) m_idx++;
                end
                if (bit_tick) begin
                    if (!line_lvl) m_cnt = 0;
                    else if (m_arm) begin
                        m_cnt++;
                        if (m_cnt == frame) begin hit = 1; m_cnt = 0; m_arm = 0; end
                    end
                end
                if (rx_stop_stb && cfg_ilt) m_arm = 1;
            end
            if (hit && !cfg_addr && old_sleep) wk = 1;
            if (sleep_req) m_sleep = 1; else if (wk) m_sleep = 0;
            if (rx_stop_stb && !old_sleep) m_rdf = 1; else if (rdf_clr) m_rdf = 0;
            if (hit && (!old_sleep || cfg_rwid)) m_idle = 1; else if (idle_clr) m_idle = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        int m_irq;
        @(posedge clk);
        #2;
        if (rst_n) begin
            m_irq = (m_rdf && ie_rx) || (m_idle && ie_idle);
            chk(sleep_o == m_sleep, "R2 sleep model", sleep_o, m_sleep);
            chk(rdf_o == m_rdf, "R9 rdf model", rdf_o, m_rdf);
            chk(idle_o == m_idle, "R7 idle model", idle_o, m_idle);
            chk(irq_o == m_irq, "R12 irq model", irq_o, m_irq);
        end
    endtask

    task automatic idle_ticks(input int n, input bit lvl);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1; line_lvl = lvl;
            cyc();
        end
        bit_tick = 0; line_lvl = 1;
    endtask

    // LSB first; optional rdf_clr asserted during the stop cycle
    task automatic send_char(input int val, input int nb, input bit clr_at_stop);
        rx_start = 1; line_lvl = 0;
        cyc();
        rx_start = 0;
        for (int i = 0; i < nb; i++) begin
            rx_data_stb = 1; bit_tick = 1; line_lvl = (val >> i) & 1;
            cyc();
            if (i == nb - 1) sleep_after_msb = sleep_o;
        end
        rx_data_stb = 0;
        rx_stop_stb = 1; bit_tick = 1; line_lvl = 1; rdf_clr = clr_at_stop;
        cyc();
        rx_stop_stb = 0; bit_tick = 0; rdf_clr = 0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1; cyc(); sleep_req = 0;
    endtask

    task automatic clear_flags();
        rdf_clr = 1; idle_clr = 1; cyc(); rdf_clr = 0; idle_clr = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk({sleep_o, rdf_o, idle_o, irq_o} == 4'b0, "R1 reset outputs", {sleep_o, rdf_o, idle_o, irq_o}, 0);
        rst_n = 1;
        cyc();

        // R2: sleep request
        pulse_sleep();
        chk(sleep_o == 1, "R2 sleep after request", sleep_o, 1);

        // R3/R4/R6/R9: idle-line wake, 8-bit, count from start
        send_char(8'hFF, 8, 0);
        chk(rdf_o == 0, "R9 asleep char no rdf", rdf_o, 0);
        chk(sleep_o == 1, "R4 nine counted ticks still asleep", sleep_o, 1);
        idle_ticks(1, 1);
        chk(sleep_o == 0, "R3 wake at tenth tick", sleep_o, 0);
        chk(idle_o == 0, "R6 waking idle sets no flag", idle_o, 0);

        // R4/R7: zero last bit restarts count
        send_char(8'h55, 8, 0);
        chk(rdf_o == 1, "R9 awake char sets rdf", rdf_o, 1);
        idle_ticks(8, 1);
        chk(idle_o == 0, "R4 count restarted by zero bit", idle_o, 0);
        idle_ticks(1, 1);
        chk(idle_o == 1, "R7 idle while awake", idle_o, 1);

        // R11 clears; R10 no re-detection without a new character
        clear_flags();
        chk(rdf_o == 0 && idle_o == 0, "R11 flags cleared", {rdf_o, idle_o}, 0);
        idle_ticks(25, 1);
        chk(idle_o == 0, "R10 no idle without new char", idle_o, 0);

        // R10: low line never idle, low tick resets count
        send_char(8'hFF, 8, 0);
        idle_ticks(30, 0);
        chk(idle_o == 0, "R10 low line not idle", idle_o, 0);
        idle_ticks(9, 1);
        chk(idle_o == 0, "R10 count restarted after low", idle_o, 0);
        idle_ticks(1, 1);
        chk(idle_o == 1, "R10 idle after ten high ticks", idle_o, 1);
        clear_flags();

        // R5/R3: count after stop, 9-bit
        cfg_ilt = 1; cfg_nine = 1;
        send_char(9'h1FF, 9, 0);
        idle_ticks(10, 1);
        chk(idle_o == 0, "R5 ten ticks after stop not enough", idle_o, 0);
        idle_ticks(1, 1);
        chk(idle_o == 1, "R5 eleven ticks after stop", idle_o, 1);
        clear_flags();

        // R7: idle flag while asleep
        cfg_ilt = 0; cfg_nine = 0; cfg_rwid = 1;
        pulse_sleep();
        send_char(8'h00, 8, 0);
        idle_ticks(8, 1);
        chk(sleep_o == 1, "R3 asleep before full time", sleep_o, 1);
        idle_ticks(1, 1);
        chk(sleep_o == 0 && idle_o == 1, "R7 asleep idle sets flag", {sleep_o, idle_o}, 1);
        clear_flags();
        cfg_rwid = 0;

        // R8/R9/R6: address-mark wake
        cfg_addr = 1;
        pulse_sleep();
        send_char(8'h7F, 8, 0);
        chk(sleep_o == 1 && rdf_o == 0, "R9 msb zero keeps sleep", {sleep_o, rdf_o}, 2);
        idle_ticks(12, 1);
        chk(sleep_o == 1, "R8 idle ignored in address mode", sleep_o, 1);
        chk(idle_o == 0, "R6 asleep idle no flag", idle_o, 0);
        send_char(8'h80, 8, 0);
        chk(sleep_after_msb == 0, "R8 wake before stop", sleep_after_msb, 0);
        chk(rdf_o == 1, "R8 waking char sets rdf", rdf_o, 1);

        // R8: 9-bit address mark uses bit 9
        cfg_nine = 1;
        clear_flags();
        pulse_sleep();
        send_char(9'h0FF, 9, 0);
        chk(sleep_o == 1, "R8 bit8 set but bit9 clear", sleep_o, 1);
        send_char(9'h100, 9, 0);
        chk(sleep_o == 0 && rdf_o == 1, "R8 bit9 wakes", {sleep_o, rdf_o}, 1);
        cfg_nine = 0;

        // R12: interrupt gating
        ie_rx = 1; cyc();
        chk(irq_o == 1, "R12 irq with rdf enabled", irq_o, 1);
        ie_rx = 0; ie_idle = 1; cyc();
        chk(irq_o == 0, "R12 irq masked", irq_o, 0);
        ie_idle = 0;

        // R11: set wins over clear
        clear_flags();
        send_char(8'h81, 8, 1);
        chk(rdf_o == 1, "R11 set beats clear", rdf_o, 1);

        // R2: request wins over a wake in the same cycle
        clear_flags();
        pulse_sleep();
        rx_start = 1; line_lvl = 0; cyc(); rx_start = 0;
        for (int i = 0; i < 8; i++) begin
            rx_data_stb = 1; bit_tick = 1; line_lvl = (i == 7);
            sleep_req = (i == 7);
            cyc();
        end
        rx_data_stb = 0; sleep_req = 0;
        chk(sleep_o == 1, "R2 request beats wake", sleep_o, 1);
        rx_stop_stb = 1; bit_tick = 1; line_lvl = 1; cyc();
        rx_stop_stb = 0; bit_tick = 0;
        cyc();

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule